// File: doc/BRIEF.md
# GPIO Interrupt Channel Router

This block picks a small number of pad signals out of a wide pad bus and turns each into an interrupt request that a parent controller can take. The parent controller understands only two kinds of request: an active-high level, or a rising edge. Each of the eight channels has its own pad selector and a filter that rejects short glitches. It can also invert its input and choose between level sensing and edge sensing, so low levels, falling edges and both-edge events all reach the parent as a high level or a one-cycle high pulse.

Software programs the block through a plain register port with an address, write data, a write strobe and combinational read data. Each pad passes through a synchronizer before it is filtered. A write that changes a channel's pad selection or trigger setup starts a quiet window on that channel. During the window no edge pulse can come out, so the change cannot cause a spurious event. A global enable bit forces every output low.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset every register reads zero and every bit of `irq_out` is low.
- R2: Register at byte offset 0x0 (trigger): bit n = edge mode for channel n, bit 8+n = both-edge mode, bit 16+n = invert, bit 31 = global enable; bits 30:24 read zero. Offset 0x4 holds the pad selectors of channels 0..3 and offset 0x8 those of channels 4..7, each an 8-bit field at bit 8*(n mod 4). Offset 0xC holds a 4-bit filter setting for channel n at bit 4n. All four registers read back what was written, and a write to any other offset changes nothing.
- R3: While the global enable bit is clear, every output is low, whatever the pads and the channel settings.
- R4: In level mode (edge and both-edge bits clear), output n equals the filtered pad value XOR the invert bit. With a filter setting of 0 or 1, a pad change driven between two clock edges appears on the output after the third following edge: two synchronizer stages and one filter stage.
- R5: In single-edge mode (edge bit set, both-edge bit clear), the output pulses high for exactly one cycle when the filtered value rises (invert clear) or falls (invert set), and at no other time.
- R6: When the both-edge bit is set, the channel gives a one-cycle pulse on every change of the filtered value, in either direction, regardless of its edge and invert bits.
- R7: Channel n follows only the pad whose index equals its selector field. Other pads have no effect on it.
- R8: With a filter setting k > 0, the filtered value takes the new synchronized value only after that value has differed from it for k consecutive cycles. Any shorter excursion is dropped. A setting of 0 passes the synchronized value through with one cycle of delay.
- R9: A write to offset 0x0 (all channels), or to the selector register that holds a channel's field, blocks edge pulses on the affected channels for 18 cycles (synchronizer stages + 16) after the write edge. Level outputs are not affected by this window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 4 | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, one write per cycle it is high |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pad_in | input | NUM_PADS (256) | Asynchronous pad signals |
| irq_out | output | 8 | Conditioned request for each channel, to the parent controller |

## Verification
The bench goes after the exact arrival cycle of a level change and the width of edge pulses. A design with an extra or missing synchronizer stage shows up as a wrong latency, and a design whose edge detector fails to track its history emits pulses longer than one cycle. It also checks that the both-edge bit wins over the edge and invert bits, and that a glitch shorter than the filter setting is dropped while a longer one gets through. A filter that counts off by one fails one of these two cases. A selector write that swaps in a pad already held high must give no pulse, and the bench drives exactly that case. Lastly, a cleared global enable must silence even an inverted level channel whose condition is true. Random register writes and pad toggling, compared cycle by cycle against a reference model in the bench, cover the combinations.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int CH_N   = 8;
  localparam int SEL_W  = 8;
  localparam int FILT_W = 4;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] ADDR_TRIG   = 4'h0;
  localparam logic [ADDR_W-1:0] ADDR_SEL_LO = 4'h4;
  localparam logic [ADDR_W-1:0] ADDR_SEL_HI = 4'h8;
  localparam logic [ADDR_W-1:0] ADDR_FILT   = 4'hC;

  localparam int EDGE_LSB = 0;
  localparam int BOTH_LSB = 8;
  localparam int INV_LSB  = 16;
  localparam int EN_BIT   = 31;

  typedef enum logic [1:0] {
    TRIG_LEVEL  = 2'd0,
    TRIG_SINGLE = 2'd1,
    TRIG_BOTH   = 2'd2
  } trig_mode_e;

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    trig_mode_e        mode;
    logic              inv;
    logic [FILT_W-1:0] filt;
  } chan_cfg_t;

endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wdata,
  input  logic                   we,
  output logic [DATA_W-1:0]      rdata,
  output chan_cfg_t [CH_N-1:0]   cfg,
  output logic                   glob_en,
  output logic [CH_N-1:0]        flush
);

  localparam int SEL_BITS  = CH_N * SEL_W;
  localparam int SEL_HALF  = SEL_BITS / 2;
  localparam int FILT_BITS = CH_N * FILT_W;
  localparam int PAD_BITS  = DATA_W - 1 - INV_LSB - CH_N;

  logic [CH_N-1:0]      edge_q, edge_d, both_q, both_d, inv_q, inv_d;
  logic                 en_q, en_d;
  logic [SEL_BITS-1:0]  sel_q, sel_d;
  logic [FILT_BITS-1:0] filt_q, filt_d;

  logic wr_trig, wr_sel_lo, wr_sel_hi, wr_filt;

  assign wr_trig   = we && (addr == ADDR_TRIG);
  assign wr_sel_lo = we && (addr == ADDR_SEL_LO);
  assign wr_sel_hi = we && (addr == ADDR_SEL_HI);
  assign wr_filt   = we && (addr == ADDR_FILT);

  // next-state values
  always_comb begin
    edge_d = wdata[EDGE_LSB +: CH_N];
    both_d = wdata[BOTH_LSB +: CH_N];
    inv_d  = wdata[INV_LSB  +: CH_N];
    en_d   = wdata[EN_BIT];
    sel_d  = sel_q;
    if (wr_sel_lo) sel_d[SEL_HALF-1:0]        = wdata[SEL_HALF-1:0];
    if (wr_sel_hi) sel_d[SEL_BITS-1:SEL_HALF] = wdata[SEL_HALF-1:0];
    filt_d = wdata[FILT_BITS-1:0];
  end

  // registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= '0;
      both_q <= '0;
      inv_q  <= '0;
      en_q   <= 1'b0;
      sel_q  <= '0;
      filt_q <= '0;
    end else begin
      if (wr_trig) begin
        edge_q <= edge_d;
        both_q <= both_d;
        inv_q  <= inv_d;
        en_q   <= en_d;
      end
      if (wr_sel_lo || wr_sel_hi) sel_q  <= sel_d;
      if (wr_filt)                filt_q <= filt_d;
    end
  end

  always_comb begin
    unique case (addr)
      ADDR_TRIG:   rdata = {en_q, {PAD_BITS{1'b0}}, inv_q, both_q, edge_q};
      ADDR_SEL_LO: rdata = sel_q[SEL_HALF-1:0];
      ADDR_SEL_HI: rdata = sel_q[SEL_BITS-1:SEL_HALF];
      ADDR_FILT:   rdata = filt_q;
      default:     rdata = '0;
    endcase
  end

  assign glob_en = en_q;

  always_comb begin
    for (int n = 0; n < CH_N; n++) begin
      cfg[n].sel  = sel_q[n*SEL_W +: SEL_W];
      cfg[n].mode = both_q[n] ? TRIG_BOTH : (edge_q[n] ? TRIG_SINGLE : TRIG_LEVEL);
      cfg[n].inv  = inv_q[n];
      cfg[n].filt = filt_q[n*FILT_W +: FILT_W];
    end
  end

  for (genvar n = 0; n < CH_N; n++) begin : g_flush
    localparam logic [ADDR_W-1:0] MY_SEL = (n < CH_N/2) ? ADDR_SEL_LO : ADDR_SEL_HI;
    assign flush[n] = we && ((addr == ADDR_TRIG) || (addr == MY_SEL));
  end

endmodule

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q, chain_d;

  assign chain_d = {chain_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_irq_filter.sv
module gpio_irq_filter #(
  parameter int FILT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din,
  input  logic [FILT_W-1:0] k,
  output logic              dout
);

  localparam int CW = FILT_W + 1;

  logic [FILT_W-1:0] cnt_q, cnt_d;
  logic              out_q, out_d;
  logic [CW-1:0]     cnt_nx;

  assign cnt_nx = {1'b0, cnt_q} + CW'(1);

  always_comb begin
    out_d = out_q;
    cnt_d = cnt_q;
    if (k == '0) begin
      out_d = din;
      cnt_d = '0;
    end else if (din == out_q) begin
      cnt_d = '0;
    end else if (cnt_nx >= {1'b0, k}) begin
      out_d = din;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_nx[FILT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign dout = out_q;

endmodule

// File: rtl/gpio_irq_chan.sv
module gpio_irq_chan
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PADS    = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] pads,
  input  chan_cfg_t           cfg,
  input  logic                glob_en,
  input  logic                flush,
  output logic                irq
);

  localparam int SEL_SPAN = 2 ** SEL_W;
  localparam int QUIET    = SYNC_STAGES + 2 ** FILT_W;
  localparam int QW       = $clog2(QUIET + 1);

  logic raw, synced, filt;
  logic prev_q, prev_d;
  logic [QW-1:0] blank_q, blank_d;
  logic quiet, cond, prev_c, hit;

  // pad selection
  if (NUM_PADS >= SEL_SPAN) begin : g_mux_full
    assign raw = pads[cfg.sel];
  end else begin : g_mux_part
    logic [SEL_SPAN-1:0] pads_ext;
    assign pads_ext = {{(SEL_SPAN-NUM_PADS){1'b0}}, pads};
    assign raw = pads_ext[cfg.sel];
  end

  gpio_irq_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
  );

  gpio_irq_filter #(.FILT_W(FILT_W)) i_filt (
    .clk(clk), .rst_n(rst_n), .din(synced), .k(cfg.filt), .dout(filt)
  );

  assign quiet = (blank_q == '0);

  always_comb begin
    prev_d = filt;
    if (flush)      blank_d = QW'(QUIET);
    else if (quiet) blank_d = blank_q;
    else            blank_d = blank_q - QW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      blank_q <= '0;
    end else begin
      prev_q  <= prev_d;
      blank_q <= blank_d;
    end
  end

  assign cond   = filt ^ cfg.inv;
  assign prev_c = prev_q ^ cfg.inv;

  always_comb begin
    unique case (cfg.mode)
      TRIG_LEVEL:  hit = cond;
      TRIG_SINGLE: hit = cond & ~prev_c & quiet;
      TRIG_BOTH:   hit = (filt ^ prev_q) & quiet;
      default:     hit = 1'b0;
    endcase
  end

  assign irq = glob_en & hit;

endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PADS    = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  input  logic                reg_we,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [CH_N-1:0]     irq_out
);

  logic [1:0]            rst_pipe_q;
  logic                  rst_core_n;
  chan_cfg_t [CH_N-1:0]  cfg;
  logic                  glob_en;
  logic [CH_N-1:0]       flush;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  gpio_irq_regs i_regs (
    .clk(clk), .rst_n(rst_core_n), .addr(reg_addr), .wdata(reg_wdata),
    .we(reg_we), .rdata(reg_rdata), .cfg(cfg), .glob_en(glob_en), .flush(flush)
  );

  for (genvar n = 0; n < CH_N; n++) begin : g_chan
    gpio_irq_chan #(.NUM_PADS(NUM_PADS), .SYNC_STAGES(SYNC_STAGES)) i_chan (
      .clk(clk), .rst_n(rst_core_n), .pads(pad_in), .cfg(cfg[n]),
      .glob_en(glob_en), .flush(flush[n]), .irq(irq_out[n])
    );
  end

endmodule

// File: rtl/gpio_irq_router_chk.sv
module gpio_irq_router_chk
  import gpio_irq_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic                 reg_we,
  input logic [DATA_W-1:0]    reg_wdata,
  input logic [CH_N-1:0]      irq_out,
  input logic                 glob_en,
  input chan_cfg_t [CH_N-1:0] cfg
);

  // R1: outputs stay low while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (irq_out == '0)
        else $error("irq_out active during reset");
    end
  end

  // R3: global enable gates every channel
  assert_enable_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |-> (irq_out == '0));

  for (genvar n = 0; n < CH_N; n++) begin : g_ch
    // R2: filter field follows the write
    assert_filt_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == ADDR_FILT) |=> (cfg[n].filt == $past(reg_wdata[n*FILT_W +: FILT_W])));

    // R5: single-edge pulses last one cycle
    assert_pulse_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[n].mode == TRIG_SINGLE && irq_out[n] && !reg_we) |=> !irq_out[n]);

    // R9: a trigger write blanks edge outputs on the next cycle
    assert_blank_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == ADDR_TRIG) |=> (cfg[n].mode == TRIG_LEVEL || !irq_out[n]));
  end

endmodule

bind gpio_irq_router gpio_irq_router_chk i_gpio_irq_router_chk (
  .clk(clk), .rst_n(rst_core_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .irq_out(irq_out), .glob_en(glob_en), .cfg(cfg)
);

// File: tb/test_gpio_irq_router.sv
module test_gpio_irq_router;

  localparam int NP = 256;

  logic        clk;
  logic        rst_n;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic        reg_we;
  logic [31:0] reg_rdata;
  logic [NP-1:0] pads;
  logic [7:0]  irq_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit cmp_on = 0;
  bit done = 0;

  gpio_irq_router #(.NUM_PADS(NP), .SYNC_STAGES(2)) i_gpio_irq_router (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .pad_in(pads), .irq_out(irq_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // ---------------- reference model ----------------
  bit       m_en;
  bit       m_edge [8];
  bit       m_both [8];
  bit       m_inv  [8];
  int       m_sel  [8];
  int       m_k    [8];
  bit       m_s1 [8];
  bit       m_s2 [8];
  bit       m_f  [8];
  bit       m_p  [8];
  int       m_cnt [8];
  int       m_bl  [8];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0;
      for (int c = 0; c < 8; c++) begin
        m_edge[c] = 0; m_both[c] = 0; m_inv[c] = 0; m_sel[c] = 0; m_k[c] = 0;
        m_s1[c] = 0; m_s2[c] = 0; m_f[c] = 0; m_p[c] = 0; m_cnt[c] = 0; m_bl[c] = 0;
      end
    end else begin
      for (int c = 0; c < 8; c++) begin
        bit nf;
        int ncnt;
        bit fl;
        nf = m_f[c];
        ncnt = m_cnt[c];
        if (m_k[c] == 0) begin
          nf = m_s2[c]; ncnt = 0;
        end else if (m_s2[c] == m_f[c]) begin
          ncnt = 0;
        end else if (m_cnt[c] + 1 >= m_k[c]) begin
          nf = m_s2[c]; ncnt = 0;
        end else begin
          ncnt = m_cnt[c] + 1;
        end
        m_p[c] = m_f[c];
        m_f[c] = nf;
        m_cnt[c] = ncnt;
        m_s2[c] = m_s1[c];
        m_s1[c] = pads[m_sel[c]];
        fl = reg_we && (reg_addr == 4'h0 || reg_addr == ((c < 4) ? 4'h4 : 4'h8));
        if (fl) m_bl[c] = 18;
        else if (m_bl[c] > 0) m_bl[c] = m_bl[c] - 1;
      end
      if (reg_we) begin
        case (reg_addr)
          4'h0: begin
            m_en = reg_wdata[31];
            for (int c = 0; c < 8; c++) begin
              m_edge[c] = reg_wdata[c];
              m_both[c] = reg_wdata[8+c];
              m_inv[c]  = reg_wdata[16+c];
            end
          end
          4'h4: for (int c = 0; c < 4; c++) m_sel[c]   = int'(reg_wdata[8*c +: 8]);
          4'h8: for (int c = 0; c < 4; c++) m_sel[c+4] = int'(reg_wdata[8*c +: 8]);
          4'hC: for (int c = 0; c < 8; c++) m_k[c]     = int'(reg_wdata[4*c +: 4]);
          default: ;
        endcase
      end
    end
  end

  function automatic logic [7:0] model_out();
    logic [7:0] r;
    for (int c = 0; c < 8; c++) begin
      bit cond, hit;
      cond = m_f[c] ^ m_inv[c];
      if (m_both[c])      hit = (m_f[c] != m_p[c]) && (m_bl[c] == 0);
      else if (m_edge[c]) hit = cond && !(m_p[c] ^ m_inv[c]) && (m_bl[c] == 0);
      else                hit = cond;
      r[c] = m_en && hit;
    end
    return r;
  endfunction

  // ---------------- checking helpers ----------------
  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) check("R4/R5/R6/R7/R8/R9 cycle model", {24'h0, irq_out}, {24'h0, model_out()});
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_pad(input int i, input logic v);
    @(negedge clk);
    pads[i] = v;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_high(input int ch, input int n, output int cnt);
    cnt = 0;
    repeat (n) begin
      @(negedge clk);
      #1 if (irq_out[ch]) cnt++;
    end
  endtask

  task automatic summary();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] d;
    int cnt;
    int seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    rst_n = 1'b0; reg_addr = '0; reg_wdata = '0; reg_we = 1'b0; pads = '0;
    wait_cyc(4);
    #1 check("R1 irq_out in reset", {24'h0, irq_out}, 32'h0);
    rst_n = 1'b1;
    wait_cyc(4);
    cmp_on = 1;

    // R1: reset values
    for (int a = 0; a < 4; a++) begin
      rd(4'(a*4), d);
      check("R1 register reset value", d, 32'h0);
    end
    #1 check("R1 irq_out after reset", {24'h0, irq_out}, 32'h0);

    // R2: register map readback
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, d); check("R2 trigger readback, reserved bits zero", d, 32'h80FF_FFFF);
    wr(4'hC, 32'h1234_5678);
    rd(4'hC, d); check("R2 filter readback", d, 32'h1234_5678);
    wr(4'h4, 32'hA1B2_C3D4);
    rd(4'h4, d); check("R2 selector low readback", d, 32'hA1B2_C3D4);
    wr(4'h8, 32'h5566_7788);
    rd(4'h8, d); check("R2 selector high readback", d, 32'h5566_7788);
    wr(4'h2, 32'h0000_0000);
    rd(4'h0, d); check("R2 write to unused offset ignored", d, 32'h80FF_FFFF);
    rd(4'h2, d); check("R2 unused offset reads zero", d, 32'h0);

    // directed channel setup
    wr(4'hC, 32'h0500_0000);
    wr(4'h4, 32'h0302_0100);
    wr(4'h8, 32'h0706_0504);
    wr(4'h0, 32'h802A_306C);
    wait_cyc(25);
    #1 check("R4 level idle state, inverted channel high", {24'h0, irq_out}, 32'h02);

    // R4: level latency
    set_pad(0, 1'b1);
    @(negedge clk); #1 check("R4 latency edge1", {31'h0, irq_out[0]}, 32'h0);
    @(negedge clk); #1 check("R4 latency edge2", {31'h0, irq_out[0]}, 32'h0);
    @(negedge clk); #1 check("R4 latency edge3", {31'h0, irq_out[0]}, 32'h1);
    set_pad(0, 1'b0);
    wait_cyc(5);

    // R5: single edges
    set_pad(2, 1'b1); count_high(2, 10, cnt); check("R5 rising pulse count", cnt, 1);
    set_pad(2, 1'b0); count_high(2, 10, cnt); check("R5 no pulse on fall", cnt, 0);
    set_pad(3, 1'b1); count_high(3, 10, cnt); check("R5 inverted: no pulse on rise", cnt, 0);
    set_pad(3, 1'b0); count_high(3, 10, cnt); check("R5 inverted: pulse on fall", cnt, 1);

    // R6: both edges, and override of edge/invert
    set_pad(4, 1'b1); count_high(4, 10, cnt); check("R6 both-edge rise", cnt, 1);
    set_pad(4, 1'b0); count_high(4, 10, cnt); check("R6 both-edge fall", cnt, 1);
    set_pad(5, 1'b1); count_high(5, 10, cnt); check("R6 override rise", cnt, 1);
    set_pad(5, 1'b0); count_high(5, 10, cnt); check("R6 override fall", cnt, 1);

    // R8: filter of 5 on channel 6
    set_pad(6, 1'b1); wait_cyc(2); set_pad(6, 1'b0);
    count_high(6, 20, cnt); check("R8 short glitch rejected", cnt, 0);
    set_pad(6, 1'b1); count_high(6, 20, cnt); check("R8 long pulse passes", cnt, 1);
    set_pad(6, 1'b0); wait_cyc(10);

    // R9: selector write onto a pad already high
    set_pad(9, 1'b1); wait_cyc(5);
    wr(4'h4, 32'h0309_0100);
    #1 check("R9 level channel unaffected by write", {31'h0, irq_out[1]}, 32'h1);
    count_high(2, 25, cnt); check("R9 no spurious pulse after selector write", cnt, 0);
    set_pad(9, 1'b0); wait_cyc(8);
    set_pad(9, 1'b1); count_high(2, 10, cnt); check("R9 pulses resume after window", cnt, 1);

    // R7: pad selection far up the bus
    wr(4'h4, 32'h0309_01C8);
    wait_cyc(25);
    set_pad(200, 1'b1); wait_cyc(5);
    #1 check("R7 channel follows selected pad", {31'h0, irq_out[0]}, 32'h1);
    set_pad(0, 1'b1); wait_cyc(5); set_pad(0, 1'b0); wait_cyc(5);
    #1 check("R7 unselected pad ignored", {31'h0, irq_out[0]}, 32'h1);
    set_pad(200, 1'b0); wait_cyc(5);
    #1 check("R7 channel drops with selected pad", {31'h0, irq_out[0]}, 32'h0);

    // R3: global enable cleared
    set_pad(200, 1'b1);
    wr(4'h0, 32'h002A_306C);
    for (int i = 0; i < 6; i++) begin
      set_pad(4, i[0]);
      @(negedge clk); #1 check("R3 outputs low while disabled", {24'h0, irq_out}, 32'h0);
    end
    pads = '0;

    // random phase: model comparison each cycle
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (($urandom % 3) == 0) pads[$urandom % 16] = ~pads[$urandom % 16];
      if (($urandom % 50) == 0) begin
        int r;
        r = int'($urandom % 4);
        reg_addr = 4'(r * 4);
        case (r)
          0: reg_wdata = ($urandom & 32'h00FF_FFFF) | ((($urandom % 8) != 0) ? 32'h8000_0000 : 32'h0);
          1, 2: reg_wdata = $urandom & 32'h0F0F_0F0F;
          default: reg_wdata = $urandom & 32'h7777_7777;
        endcase
        reg_we = 1'b1;
      end else begin
        reg_we = 1'b0;
      end
    end
    @(negedge clk);
    reg_we = 1'b0;
    wait_cyc(5);
    summary();
  end

endmodule